// File: doc/BRIEF.md
# Dynamic Home Tile Lookup Unit

This unit decides where a cache block lives in a 16-tile multiprocessor whose L2 banks are grouped into per-core clusters of variable size. A core's cluster spans 1, 2, 4, 8 or 16 tiles. A block's placement tile is formed by mixing bits of the block's 4-bit home-select field with bits of the requesting core's ID. A mask chooses which bits come from which source, and that mask depends on the cluster size. The static home tile is the home-select field taken as it is.

The placement path is purely combinational. The caller gives a home-select value, a core ID and a cluster-size code, and reads back the dynamic and static home tiles in the same cycle.

The lookup path serves reads. The block may have been placed under any cluster size the core has used, so every possible tile has to be probed. A request carrying a home-select value and a core ID is accepted over a valid/ready handshake. The unit then streams the distinct candidate tiles, one per beat, on a second valid/ready channel, and marks the final beat with a last flag. Back-pressure rules: the output holds its beat while `cand_ready` is low, and the input stays closed (`lkp_ready` low) until the whole candidate list has drained.

Top module: `dht_lookup_unit`

## Requirements
- R1: `dyn_home` = (`plc_hs` AND M) OR (`plc_core` AND NOT M). M is selected by the size code `plc_dim_log2` (cluster size = 2^code): code 4 gives 1111, code 3 gives 0111, code 2 gives 0101, code 1 gives 0001, code 0 gives 0000.
- R2: `static_home` always equals `plc_hs`. Code 4 yields `dyn_home` equal to `static_home`, and codes 5 to 7 behave exactly like code 4.
- R3: `lkp_ready` is high exactly when no candidate beat is pending. A request is taken on a cycle where both `lkp_valid` and `lkp_ready` are high.
- R4: The first candidate beat is presented in the cycle after acceptance, and its tile equals the accepted home-select value (the size-16 candidate).
- R5: Candidates are emitted in mask order for sizes 16, 8, 4, 2 and 1. A tile equal to an earlier candidate of the same request is skipped, so each distinct tile appears exactly once.
- R6: `cand_last` is high only on the final distinct candidate. A request yields between 1 and 5 beats.
- R7: While `cand_valid` is high and `cand_ready` is low, `cand_valid`, `cand_tile` and `cand_last` stay unchanged on the next cycle.
- R8: After reset, `cand_valid` is low and `lkp_ready` is high.
- R9: `lkp_valid` and the request fields are ignored while a list is draining: the list emitted is the one captured at acceptance.
- R10: With code 0, `dyn_home` equals `plc_core`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| plc_hs | input | 4 | Home-select field for placement |
| plc_core | input | 4 | Requesting core ID for placement |
| plc_dim_log2 | input | 3 | Cluster size code, size = 2^code |
| dyn_home | output | 4 | Dynamic home tile |
| static_home | output | 4 | Static home tile |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup request can be taken |
| lkp_hs | input | 4 | Home-select field for lookup |
| lkp_core | input | 4 | Requesting core ID for lookup |
| cand_valid | output | 1 | Candidate beat valid |
| cand_ready | input | 1 | Consumer takes candidate beat |
| cand_tile | output | 4 | Candidate tile number |
| cand_last | output | 1 | Final candidate of this request |

## Verification
The bench builds the unit with its default tile width of 4 bits, which is the 16-tile configuration that the mask values are defined for. At this width the placement path can be swept exhaustively over every home-select value, core ID and all eight size codes, including the three codes above the largest size.

Lookups cover lists of one, three and five beats, among them the two worked mapping cases. The output channel is run under a stalling ready pattern, a free-running ready and a full stop. The full stop also exposes the ignored-input window of a draining request.

// File: rtl/dht_pkg.sv
package dht_pkg;
  localparam int MAX_W = 16;

  // Mask with k bits enabled; bits open in the order: even positions
  // ascending, then odd positions ascending (4 bits: 0,2,1,3).
  function automatic logic [MAX_W-1:0] dim_mask(input int w, input int k);
    logic [MAX_W-1:0] m;
    int n;
    m = '0;
    n = 0;
    for (int p = 0; p < MAX_W; p += 2) begin
      if (p < w && n < k) begin
        m[p] = 1'b1;
        n++;
      end
    end
    for (int p = 1; p < MAX_W; p += 2) begin
      if (p < w && n < k) begin
        m[p] = 1'b1;
        n++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/dht_mask_map.sv
module dht_mask_map #(
  parameter int TILE_W = 4,
  parameter int DIM_W  = $clog2(TILE_W + 1)
) (
  input  logic [TILE_W-1:0] hs,
  input  logic [TILE_W-1:0] core,
  input  logic [DIM_W-1:0]  dim_log2,
  output logic [TILE_W-1:0] tile
);
  import dht_pkg::*;

  logic [TILE_W-1:0] mask;

  always_comb begin
    int k;
    k = int'(dim_log2);
    if (k > TILE_W) k = TILE_W;
    mask = dim_mask(TILE_W, k)[TILE_W-1:0];
    tile = (hs & mask) | (core & ~mask);
  end
endmodule

// File: rtl/dht_cand_gen.sv
module dht_cand_gen #(
  parameter int TILE_W = 4,
  localparam int NUM_C = TILE_W + 1,
  localparam int DIM_W = $clog2(TILE_W + 1)
) (
  input  logic [TILE_W-1:0]            hs,
  input  logic [TILE_W-1:0]            core,
  output logic [NUM_C-1:0][TILE_W-1:0] cands,
  output logic [NUM_C-1:0]             keep
);
  // Slot 0 is the largest cluster, slot NUM_C-1 the single-tile cluster.
  for (genvar j = 0; j < NUM_C; j++) begin : g_slot
    localparam logic [DIM_W-1:0] DIM_CODE = DIM_W'(TILE_W - j);
    dht_mask_map #(.TILE_W(TILE_W), .DIM_W(DIM_W)) map_i (
      .hs(hs), .core(core), .dim_log2(DIM_CODE), .tile(cands[j])
    );
  end

  always_comb begin
    for (int j = 0; j < NUM_C; j++) begin
      keep[j] = 1'b1;
      for (int i = 0; i < j; i++)
        if (cands[i] == cands[j]) keep[j] = 1'b0;
    end
  end
endmodule

// File: rtl/dht_cand_stream.sv
module dht_cand_stream #(
  parameter int TILE_W = 4,
  localparam int NUM_C = TILE_W + 1,
  localparam int SEL_W = $clog2(NUM_C)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NUM_C-1:0][TILE_W-1:0] cands,
  input  logic [NUM_C-1:0]             keep,
  output logic                         idle,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [TILE_W-1:0]            out_tile,
  output logic                         out_last
);
  logic [NUM_C-1:0]             pend_q;
  logic [NUM_C-1:0][TILE_W-1:0] tiles_q;
  logic [SEL_W-1:0]             sel;

  assign idle      = (pend_q == '0);
  assign out_valid = !idle;

  always_comb begin
    logic found;
    sel   = '0;
    found = 1'b0;
    for (int j = 0; j < NUM_C; j++) begin
      if (pend_q[j] && !found) begin
        sel   = SEL_W'(j);
        found = 1'b1;
      end
    end
  end

  assign out_tile = tiles_q[sel];
  assign out_last = out_valid && ((pend_q & (pend_q - 1'b1)) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      tiles_q <= '0;
    end else if (load) begin
      pend_q  <= keep;
      tiles_q <= cands;
    end else if (out_valid && out_ready) begin
      pend_q[sel] <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tile) && $stable(out_last))); // R7

  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !load) |=> !out_valid); // R6

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid); // R3
endmodule

// File: rtl/dht_lookup_unit.sv
module dht_lookup_unit #(
  parameter int TILE_W = 4,
  localparam int DIM_W = $clog2(TILE_W + 1),
  localparam int NUM_C = TILE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TILE_W-1:0] plc_hs,
  input  logic [TILE_W-1:0] plc_core,
  input  logic [DIM_W-1:0]  plc_dim_log2,
  output logic [TILE_W-1:0] dyn_home,
  output logic [TILE_W-1:0] static_home,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [TILE_W-1:0] lkp_hs,
  input  logic [TILE_W-1:0] lkp_core,
  output logic              cand_valid,
  input  logic              cand_ready,
  output logic [TILE_W-1:0] cand_tile,
  output logic              cand_last
);
  logic [NUM_C-1:0][TILE_W-1:0] cands;
  logic [NUM_C-1:0]             keep;
  logic                         idle;
  logic                         take;

  dht_mask_map #(.TILE_W(TILE_W), .DIM_W(DIM_W)) place_i (
    .hs(plc_hs), .core(plc_core), .dim_log2(plc_dim_log2), .tile(dyn_home)
  );

  assign static_home = plc_hs;

  dht_cand_gen #(.TILE_W(TILE_W)) gen_i (
    .hs(lkp_hs), .core(lkp_core), .cands(cands), .keep(keep)
  );

  assign lkp_ready = idle;
  assign take      = lkp_valid && lkp_ready;

  dht_cand_stream #(.TILE_W(TILE_W)) strm_i (
    .clk(clk), .rst_n(rst_n), .load(take), .cands(cands), .keep(keep),
    .idle(idle), .out_valid(cand_valid), .out_ready(cand_ready),
    .out_tile(cand_tile), .out_last(cand_last)
  );

  AST_FULL_DIM_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(plc_dim_log2) >= TILE_W) |-> (dyn_home == static_home)); // R2

  AST_UNIT_DIM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (plc_dim_log2 == '0) |-> (dyn_home == plc_core)); // R10

  AST_FIRST_IS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cand_valid && cand_tile == $past(lkp_hs))); // R4

  AST_READY_XOR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_ready != cand_valid); // R3
endmodule

// File: tb/dht_lookup_unit_tb_top.sv
module dht_lookup_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] plc_hs = '0, plc_core = '0;
  logic [2:0] plc_dim_log2 = '0;
  logic [3:0] dyn_home, static_home;
  logic lkp_valid = 1'b0, lkp_ready;
  logic [3:0] lkp_hs = '0, lkp_core = '0;
  logic cand_valid, cand_ready = 1'b0, cand_last;
  logic [3:0] cand_tile;

  int total = 0;
  int bad = 0;
  int stall_mode = 0; // 0 patterned, 1 hold low, 2 hold high
  logic [4:0] exp_q[$];

  always #10 clk = ~clk;

  dht_lookup_unit dut_i (
    .clk(clk), .rst_n(rst_n), .plc_hs(plc_hs), .plc_core(plc_core),
    .plc_dim_log2(plc_dim_log2), .dyn_home(dyn_home), .static_home(static_home),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_hs(lkp_hs),
    .lkp_core(lkp_core), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_tile(cand_tile), .cand_last(cand_last)
  );

  function automatic logic [3:0] bm(input int code);
    case (code)
      0: return 4'b0000;
      1: return 4'b0001;
      2: return 4'b0101;
      3: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_expected(input logic [3:0] hs, input logic [3:0] core);
    logic [3:0] lst[$];
    for (int k = 4; k >= 0; k--) begin
      logic [3:0] t;
      bit dup;
      t = (hs & bm(k)) | (core & ~bm(k));
      dup = 1'b0;
      foreach (lst[i]) if (lst[i] == t) dup = 1'b1;
      if (!dup) lst.push_back(t);
    end
    foreach (lst[i]) exp_q.push_back({(i == lst.size() - 1), lst[i]});
  endtask

  task automatic send(input logic [3:0] hs, input logic [3:0] core);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_hs = hs; lkp_core = core;
    #1;
    while (!lkp_ready) begin @(negedge clk); #1; end
    push_expected(hs, core);
    @(posedge clk); #1;
    lkp_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    int cyc;
    bit held;
    logic [4:0] held_v;
    cyc = 0; held = 1'b0; held_v = '0;
    forever begin
      @(negedge clk);
      cyc++;
      cand_ready = (stall_mode == 1) ? 1'b0 : (stall_mode == 2) ? 1'b1 : ((cyc % 3) != 1);
      #1;
      if (rst_n) begin
        if (held) check(cand_valid && {cand_last, cand_tile} == held_v, "R7 hold",
                        {cand_valid, cand_last, cand_tile}, {1'b1, held_v});
        held = cand_valid && !cand_ready;
        held_v = {cand_last, cand_tile};
        if (cand_valid && cand_ready) begin
          if (exp_q.size() == 0) check(1'b0, "R5 unexpected beat", cand_tile, 0);
          else begin
            logic [4:0] e;
            e = exp_q.pop_front();
            check(cand_tile == e[3:0], "R5 tile", cand_tile, e[3:0]);
            check(cand_last == e[4], "R6 last", cand_last, e[4]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(cand_valid == 1'b0, "R8 valid", cand_valid, 0);
    check(lkp_ready == 1'b1, "R8 ready", lkp_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R10 exhaustive placement sweep
    for (int h = 0; h < 16; h++)
      for (int c = 0; c < 16; c++)
        for (int d = 0; d < 8; d++) begin
          logic [3:0] e;
          plc_hs = 4'(h); plc_core = 4'(c); plc_dim_log2 = 3'(d);
          #1;
          e = (plc_hs & bm(d)) | (plc_core & ~bm(d));
          check(dyn_home == e, "R1 dyn_home", dyn_home, e);
          check(static_home == plc_hs, "R2 static", static_home, plc_hs);
          if (d >= 4) check(dyn_home == static_home, "R2 clamp", dyn_home, static_home);
          if (d == 0) check(dyn_home == plc_core, "R10 core", dyn_home, plc_core);
        end

    // R4 first beat timing on a lone request
    stall_mode = 2;
    @(negedge clk);
    lkp_valid = 1'b1; lkp_hs = 4'b1010; lkp_core = 4'b0011;
    push_expected(4'b1010, 4'b0011);
    @(posedge clk); #1;
    lkp_valid = 1'b0;
    check(cand_valid && cand_tile == 4'b1010, "R4 first beat", cand_tile, 4'b1010);
    check(lkp_ready == 1'b0, "R3 busy", lkp_ready, 0);
    wait (exp_q.size() == 0);

    // Worked cases: 3 beats and 5 beats; single beat
    stall_mode = 0;
    send(4'b1111, 4'b0101);
    send(4'b1111, 4'b0000);
    send(4'b0110, 4'b0110);
    for (int i = 0; i < 30; i++) send(4'((i * 7 + 3) % 16), 4'((i * 5 + 9) % 16));

    // R9: garbage while draining under a full stop
    wait (exp_q.size() == 0);
    stall_mode = 1;
    send(4'b1100, 4'b0011);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      lkp_valid = 1'b1; lkp_hs = 4'(i); lkp_core = 4'(15 - i);
      #1;
      check(lkp_ready == 1'b0, "R9 closed", lkp_ready, 0);
    end
    @(negedge clk); lkp_valid = 1'b0;
    stall_mode = 2;
    wait (exp_q.size() == 0);
    repeat (3) @(posedge clk);
    #1;
    check(lkp_ready && !cand_valid, "R3 idle", {lkp_ready, cand_valid}, 2'b10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule